// File: doc/BRIEF.md
# Queue Interrupt Status Aggregator

This block collects per-endpoint event strobes from a set of transmit and receive queue engines and turns them into sticky status bits, which software reads and clears through a small register port. Completion events for both directions share one 32-bit word: transmit endpoints sit in the low half and receive endpoints in the high half. Error events are recorded per endpoint in three detail words, one for receive checksum and length errors, one for receive zero-length errors and one for transmit checksum and length errors. Recording into the detail words is gated by a per-endpoint error enable word.

A read-only exception summary word holds one bit per error kind. Each bit is the OR of the matching field of a detail word, so software can tell which detail word to look at. Two enable words qualify the completion bits and the summary bits. A single registered interrupt line is the OR of every qualified bit. Endpoint 0 never raises queue events, so its positions always read zero.

Register port: a request with the write flag set updates the addressed word at the clock edge. A request with the write flag clear returns the addressed word on the read data output one cycle later.

Top module: `qisa_top`

## Requirements
- R1: A done strobe on transmit endpoint n sets bit n of the done word (address 0), and one on receive endpoint n sets bit 16+n. A set bit stays set until it is cleared.
- R2: A write to address 0 clears every done bit whose write data bit is 1 and leaves every bit written with 0 unchanged.
- R3: If an event strobe and a write-1-to-clear of the same bit fall in the same cycle, the bit ends up set. This applies to the done word and to the detail words.
- R4: Strobes on endpoint 0 and on endpoints at or above EP_COUNT have no effect. Bits 0 and 16 of the done word and of both two-field detail words, and bit 0 of the zero-length word, always read 0.
- R5: The error enable word (address 7) gates recording of errors. Bit n enables receive errors of endpoint n and bit 16+n enables transmit errors of endpoint n. An error strobe for a disabled endpoint records nothing.
- R6: Detail layout: address 4 holds receive checksum errors at bit n and receive length errors at bit 16+n. Address 5 holds receive zero-length errors at bit n. Address 6 holds transmit checksum errors at bit n and transmit length errors at bit 16+n.
- R7: The summary word (address 2) is read-only. Its bits are: bit 0 receive checksum, bit 1 receive length, bit 2 receive zero-length, bit 3 transmit checksum, bit 4 transmit length. Each bit is 1 exactly when its detail field is non-zero.
- R8: Writing a detail word clears the bits that are 1 in the write data, so writing back the value just read clears that word.
- R9: irq_o is the registered OR of (done AND done enable at address 1) and (summary AND exception enable at address 3, bits [4:0]). It follows a status change by one cycle.
- R10: After reset, every register reads 0 and irq_o is low.
- R11: Read data appears one cycle after a read request. Addresses 8 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_done_i | input | EP_COUNT | Transmit completion strobe per endpoint |
| rx_done_i | input | EP_COUNT | Receive completion strobe per endpoint |
| tx_len_err_i | input | EP_COUNT | Transmit length error strobe |
| tx_cs_err_i | input | EP_COUNT | Transmit checksum error strobe |
| rx_len_err_i | input | EP_COUNT | Receive length error strobe |
| rx_cs_err_i | input | EP_COUNT | Receive checksum error strobe |
| rx_zlp_err_i | input | EP_COUNT | Receive zero-length error strobe |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Write flag of the request |
| reg_addr_i | input | 4 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after a read |
| irq_o | output | 1 | Registered interrupt |

## Verification
A wrong sticky bit shows up on the next read of its word, and it reaches irq_o one cycle after the edge that stored it, provided its enable is set. A bad gating or packing decision puts a bit at the wrong position in the done or detail words. Because the summary word is computed from the detail words, a broken detail field is also seen in the summary and on the interrupt within two cycles. The bench keeps a model of every word and compares all eight addresses and the interrupt line after directed corner cases and after bursts of random strobes mixed with writes.

// File: rtl/qisa_pkg.sv
package qisa_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;
    localparam int EXC_W  = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_DONE    = 4'd0,
        A_DONE_EN = 4'd1,
        A_SUMMARY = 4'd2,
        A_EXC_EN  = 4'd3,
        A_RX_ERR  = 4'd4,
        A_RX_ZLP  = 4'd5,
        A_TX_ERR  = 4'd6,
        A_ERR_EN  = 4'd7
    } reg_sel_e;

    // summary bit positions
    localparam int S_RX_CS  = 0;
    localparam int S_RX_LEN = 1;
    localparam int S_RX_ZLP = 2;
    localparam int S_TX_CS  = 3;
    localparam int S_TX_LEN = 4;

    function automatic logic [HALF_W-1:0] ep_mask(input int n);
        logic [HALF_W-1:0] m;
        for (int e = 0; e < HALF_W; e++) m[e] = (e >= 1) && (e < n);
        return m;
    endfunction
endpackage

// File: rtl/qisa_sticky_bank.sv
module qisa_sticky_bank #(
    parameter int W = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_nx;

    // set has priority over a same-cycle clear
    always_comb q_nx = ((q_o & ~clr_i) | set_i) & KEEP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= q_nx;
    end
endmodule

// File: rtl/qisa_irq_gen.sv
module qisa_irq_gen #(
    parameter int DW = 32,
    parameter int EW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] done_i,
    input  logic [DW-1:0] done_en_i,
    input  logic [EW-1:0] summ_i,
    input  logic [EW-1:0] exc_en_i,
    output logic          irq_o
);
    logic irq_nx;

    always_comb irq_nx = (|(done_i & done_en_i)) | (|(summ_i & exc_en_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= irq_nx;
    end
endmodule

// File: rtl/qisa_top.sv
module qisa_top
    import qisa_pkg::*;
#(
    parameter int EP_COUNT = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [EP_COUNT-1:0] tx_done_i,
    input  logic [EP_COUNT-1:0] rx_done_i,
    input  logic [EP_COUNT-1:0] tx_len_err_i,
    input  logic [EP_COUNT-1:0] tx_cs_err_i,
    input  logic [EP_COUNT-1:0] rx_len_err_i,
    input  logic [EP_COUNT-1:0] rx_cs_err_i,
    input  logic [EP_COUNT-1:0] rx_zlp_err_i,
    input  logic                reg_req_i,
    input  logic                reg_we_i,
    input  logic [3:0]          reg_addr_i,
    input  logic [31:0]         reg_wdata_i,
    output logic [31:0]         reg_rdata_o,
    output logic                irq_o
);
    localparam logic [HALF_W-1:0] EPM  = ep_mask(EP_COUNT);
    localparam logic [WORD_W-1:0] DUAL = {EPM, EPM};

    logic              wr;
    logic [WORD_W-1:0] done_q, rx_err_q, tx_err_q;
    logic [HALF_W-1:0] rx_zlp_q;
    logic [WORD_W-1:0] done_en_q, err_en_q;
    logic [EXC_W-1:0]  exc_en_q, summ;
    logic [WORD_W-1:0] done_set, rx_err_set, tx_err_set;
    logic [HALF_W-1:0] rx_zlp_set;
    logic [WORD_W-1:0] done_clr, rx_err_clr, tx_err_clr;
    logic [HALF_W-1:0] rx_zlp_clr;
    logic [WORD_W-1:0] rdata_nx;

    always_comb wr = reg_req_i & reg_we_i;

    // event packing: transmit low half, receive high half; error capture gated
    always_comb begin
        done_set   = {HALF_W'(rx_done_i), HALF_W'(tx_done_i)};
        rx_err_set = {HALF_W'(rx_len_err_i) & err_en_q[HALF_W-1:0],
                      HALF_W'(rx_cs_err_i)  & err_en_q[HALF_W-1:0]};
        rx_zlp_set = HALF_W'(rx_zlp_err_i) & err_en_q[HALF_W-1:0];
        tx_err_set = {HALF_W'(tx_len_err_i) & err_en_q[WORD_W-1:HALF_W],
                      HALF_W'(tx_cs_err_i)  & err_en_q[WORD_W-1:HALF_W]};
    end

    always_comb begin
        done_clr   = (wr && reg_addr_i == A_DONE)   ? reg_wdata_i : '0;
        rx_err_clr = (wr && reg_addr_i == A_RX_ERR) ? reg_wdata_i : '0;
        rx_zlp_clr = (wr && reg_addr_i == A_RX_ZLP) ? reg_wdata_i[HALF_W-1:0] : '0;
        tx_err_clr = (wr && reg_addr_i == A_TX_ERR) ? reg_wdata_i : '0;
    end

    qisa_sticky_bank #(.W(WORD_W), .KEEP(DUAL)) u_done (
        .clk(clk), .rst_n(rst_n), .set_i(done_set), .clr_i(done_clr), .q_o(done_q));
    qisa_sticky_bank #(.W(WORD_W), .KEEP(DUAL)) u_rx_err (
        .clk(clk), .rst_n(rst_n), .set_i(rx_err_set), .clr_i(rx_err_clr), .q_o(rx_err_q));
    qisa_sticky_bank #(.W(HALF_W), .KEEP(EPM)) u_rx_zlp (
        .clk(clk), .rst_n(rst_n), .set_i(rx_zlp_set), .clr_i(rx_zlp_clr), .q_o(rx_zlp_q));
    qisa_sticky_bank #(.W(WORD_W), .KEEP(DUAL)) u_tx_err (
        .clk(clk), .rst_n(rst_n), .set_i(tx_err_set), .clr_i(tx_err_clr), .q_o(tx_err_q));

    // exception summary derived from the detail words
    always_comb begin
        summ           = '0;
        summ[S_RX_CS]  = |rx_err_q[HALF_W-1:0];
        summ[S_RX_LEN] = |rx_err_q[WORD_W-1:HALF_W];
        summ[S_RX_ZLP] = |rx_zlp_q;
        summ[S_TX_CS]  = |tx_err_q[HALF_W-1:0];
        summ[S_TX_LEN] = |tx_err_q[WORD_W-1:HALF_W];
    end

    // enable words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_en_q <= '0;
            exc_en_q  <= '0;
            err_en_q  <= '0;
        end else if (wr) begin
            unique case (reg_addr_i)
                A_DONE_EN: done_en_q <= reg_wdata_i;
                A_EXC_EN:  exc_en_q  <= reg_wdata_i[EXC_W-1:0];
                A_ERR_EN:  err_en_q  <= reg_wdata_i;
                default:   ;
            endcase
        end
    end

    // read mux
    always_comb begin
        unique case (reg_addr_i)
            A_DONE:    rdata_nx = done_q;
            A_DONE_EN: rdata_nx = done_en_q;
            A_SUMMARY: rdata_nx = WORD_W'(summ);
            A_EXC_EN:  rdata_nx = WORD_W'(exc_en_q);
            A_RX_ERR:  rdata_nx = rx_err_q;
            A_RX_ZLP:  rdata_nx = WORD_W'(rx_zlp_q);
            A_TX_ERR:  rdata_nx = tx_err_q;
            A_ERR_EN:  rdata_nx = err_en_q;
            default:   rdata_nx = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      reg_rdata_o <= '0;
        else if (reg_req_i && !reg_we_i) reg_rdata_o <= rdata_nx;
    end

    qisa_irq_gen #(.DW(WORD_W), .EW(EXC_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .done_i(done_q), .done_en_i(done_en_q),
        .summ_i(summ), .exc_en_i(exc_en_q),
        .irq_o(irq_o));
endmodule

// File: rtl/qisa_chk.sv
module qisa_chk #(
    parameter int EP_COUNT = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [EP_COUNT-1:0] tx_done_i,
    input logic                reg_req_i,
    input logic                reg_we_i,
    input logic [3:0]          reg_addr_i,
    input logic [31:0]         reg_wdata_i,
    input logic                irq_o,
    input logic [31:0]         done_q,
    input logic [31:0]         done_en_q,
    input logic [31:0]         rx_err_q,
    input logic [31:0]         err_en_q,
    input logic [4:0]          summ,
    input logic [4:0]          exc_en_q
);
    logic pend;
    always_comb pend = (|(done_q & done_en_q)) | (|(summ & exc_en_q));

    // R1
    done_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_i[1] |=> done_q[1]);

    // R2
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_i && reg_we_i && reg_addr_i == 4'd0 && reg_wdata_i[1] && !tx_done_i[1])
        |=> !done_q[1]);

    // R4
    ep0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q[0] && !done_q[16]);

    // R5
    err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_en_q[1] && !(reg_req_i && reg_we_i && reg_addr_i == 4'd4))
        |=> rx_err_q[1] == $past(rx_err_q[1]));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> irq_o);

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> !irq_o);
endmodule

bind qisa_top qisa_chk #(.EP_COUNT(EP_COUNT)) u_qisa_chk (
    .clk(clk), .rst_n(rst_n), .tx_done_i(tx_done_i),
    .reg_req_i(reg_req_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .irq_o(irq_o),
    .done_q(done_q), .done_en_q(done_en_q), .rx_err_q(rx_err_q),
    .err_en_q(err_en_q), .summ(summ), .exc_en_q(exc_en_q));

// File: tb/qisa_top_test.sv
module qisa_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NEP = 16;
    localparam logic [15:0] EPM = 16'hFFFE;
    localparam logic [31:0] VM  = {EPM, EPM};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NEP-1:0] tx_done, rx_done, tx_len, tx_cs, rx_len, rx_cs, rx_zlp;
    logic req, we;
    logic [3:0] addr;
    logic [31:0] wdata, rdata;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] m_done, m_den, m_rxe, m_txe, m_een;
    logic [15:0] m_zlp;
    logic [4:0]  m_exen;

    always #(CLK_PERIOD/2) clk = ~clk;

    qisa_top #(.EP_COUNT(NEP)) uut (
        .clk(clk), .rst_n(rst_n),
        .tx_done_i(tx_done), .rx_done_i(rx_done),
        .tx_len_err_i(tx_len), .tx_cs_err_i(tx_cs),
        .rx_len_err_i(rx_len), .rx_cs_err_i(rx_cs), .rx_zlp_err_i(rx_zlp),
        .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

    function automatic logic [4:0] exp_summ();
        return {|m_txe[31:16], |m_txe[15:0], |m_zlp, |m_rxe[31:16], |m_rxe[15:0]};
    endfunction

    function automatic logic exp_irq();
        return (|(m_done & m_den)) | (|(exp_summ() & m_exen));
    endfunction

    function automatic logic [31:0] exp_reg(input logic [3:0] a);
        case (a)
            4'd0: return m_done;
            4'd1: return m_den;
            4'd2: return {27'd0, exp_summ()};
            4'd3: return {27'd0, m_exen};
            4'd4: return m_rxe;
            4'd5: return {16'd0, m_zlp};
            4'd6: return m_txe;
            4'd7: return m_een;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic clear_strobes();
        tx_done = '0; rx_done = '0; tx_len = '0; tx_cs = '0;
        rx_len = '0; rx_cs = '0; rx_zlp = '0;
    endtask

    // drive one cycle (called at a falling edge), update the model from old state
    task automatic step(input logic r, input logic w, input logic [3:0] a, input logic [31:0] d);
        logic [31:0] wd;
        logic [31:0] se;
        req = r; we = w; addr = a; wdata = d;
        wd = (r && w) ? d : 32'd0;
        se = m_een;
        m_done = ((m_done & ~((a == 4'd0) ? wd : 32'd0)) | {rx_done, tx_done}) & VM;
        m_rxe  = ((m_rxe & ~((a == 4'd4) ? wd : 32'd0)) |
                  {rx_len & se[15:0], rx_cs & se[15:0]}) & VM;
        m_zlp  = ((m_zlp & ~((a == 4'd5) ? wd[15:0] : 16'd0)) | (rx_zlp & se[15:0])) & EPM;
        m_txe  = ((m_txe & ~((a == 4'd6) ? wd : 32'd0)) |
                  {tx_len & se[31:16], tx_cs & se[31:16]}) & VM;
        if (r && w) begin
            if (a == 4'd1) m_den  = d;
            if (a == 4'd3) m_exen = d[4:0];
            if (a == 4'd7) m_een  = d;
        end
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        clear_strobes();
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 4'd0, 32'd0);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d);
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a);
        step(1'b1, 1'b0, a, 32'd0);
        check(tag, rdata, exp_reg(a));
    endtask

    task automatic irq_chk(input string tag);
        idle();
        check(tag, {31'd0, irq}, {31'd0, exp_irq()});
    endtask

    task automatic all_chk(input string tag);
        for (int a = 0; a < 8; a++) rd_chk(tag, a[3:0]);
        irq_chk({tag, " R9 irq"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_strobes();
        req = 0; we = 0; addr = 0; wdata = 0;
        m_done = 0; m_den = 0; m_rxe = 0; m_txe = 0; m_een = 0; m_zlp = 0; m_exen = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 irq after reset", {31'd0, irq}, 32'd0);
        all_chk("R10 reset");
        // R11 unmapped addresses
        rd_chk("R11 unmapped 9", 4'd9);
        rd_chk("R11 unmapped 15", 4'd15);

        // R1 capture and stickiness
        tx_done[3] = 1; rx_done[5] = 1; idle();
        rd_chk("R1 done capture", 4'd0);
        check("R1 packing", rdata, 32'h0020_0008);
        idle(); idle();
        rd_chk("R1 sticky", 4'd0);

        // R4 endpoint 0 ignored
        tx_done[0] = 1; rx_done[0] = 1; idle();
        rd_chk("R4 ep0 ignored", 4'd0);
        check("R4 ep0 value", rdata, 32'h0020_0008);

        // R2 write-1-to-clear and write-0 no effect
        wr_reg(4'd0, 32'h0000_0000);
        rd_chk("R2 write zero keeps", 4'd0);
        wr_reg(4'd0, 32'h0000_0008);
        rd_chk("R2 clear bit3", 4'd0);
        check("R2 value", rdata, 32'h0020_0000);

        // R3 set wins against same-cycle clear
        tx_done[5] = 1;
        wr_reg(4'd0, 32'h0000_0020);
        rd_chk("R3 set wins", 4'd0);
        check("R3 value", rdata, 32'h0020_0020);

        // R9 irq qualified by done enable
        irq_chk("R9 no enable");
        wr_reg(4'd1, 32'h0020_0000);
        irq_chk("R9 enabled rx5");
        check("R9 irq high", {31'd0, irq}, 32'd1);
        wr_reg(4'd0, 32'h0020_0020);
        irq_chk("R9 cleared");
        check("R9 irq low", {31'd0, irq}, 32'd0);

        // R5 gating of error recording
        rx_cs[2] = 1; tx_len[4] = 1; idle();
        rd_chk("R5 rx gated", 4'd4);
        rd_chk("R5 tx gated", 4'd6);
        wr_reg(4'd7, 32'h0010_0004);
        rx_cs[2] = 1; rx_len[2] = 1; rx_zlp[2] = 1; tx_cs[4] = 1; tx_len[4] = 1;
        rx_cs[3] = 1; idle();
        // R6 layout
        rd_chk("R6 rx detail", 4'd4);
        check("R6 rx value", rdata, 32'h0004_0004);
        rd_chk("R6 zlp detail", 4'd5);
        check("R6 zlp value", rdata, 32'h0000_0004);
        rd_chk("R6 tx detail", 4'd6);
        check("R6 tx value", rdata, 32'h0010_0010);
        // R7 summary
        rd_chk("R7 summary", 4'd2);
        check("R7 value", rdata, 32'h0000_001F);
        wr_reg(4'd2, 32'h0000_0000);
        rd_chk("R7 read-only", 4'd2);
        wr_reg(4'd3, 32'h0000_0004);
        irq_chk("R9 exception enable");
        // R8 write back read value
        rd_chk("R8 read rx", 4'd4);
        wr_reg(4'd4, rdata);
        rd_chk("R8 rx cleared", 4'd4);
        check("R8 zero", rdata, 32'd0);
        rd_chk("R8 summary after clear", 4'd2);
        // R3 on a detail word
        rx_zlp[2] = 1;
        wr_reg(4'd5, 32'h0000_0004);
        rd_chk("R3 detail set wins", 4'd5);
        wr_reg(4'd5, 32'h0000_0004);
        rd_chk("R8 zlp cleared", 4'd5);
        irq_chk("R9 after zlp clear");

        // random phase
        for (int it = 0; it < 600; it++) begin
            tx_done = 16'($urandom) & 16'($urandom);
            rx_done = 16'($urandom) & 16'($urandom);
            tx_len  = 16'($urandom) & 16'($urandom) & 16'($urandom);
            tx_cs   = 16'($urandom) & 16'($urandom) & 16'($urandom);
            rx_len  = 16'($urandom) & 16'($urandom) & 16'($urandom);
            rx_cs   = 16'($urandom) & 16'($urandom) & 16'($urandom);
            rx_zlp  = 16'($urandom) & 16'($urandom) & 16'($urandom);
            if (($urandom % 10) < 3) begin
                wr_reg(4'($urandom % 8), $urandom);
            end else begin
                idle();
            end
            if ((it % 40) == 39) all_chk("R1 R5 R6 R7 R8 random");
        end
        all_chk("R2 R3 random final");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule